// File: doc/BRIEF.md
# K-line transceiver control with short-to-battery timeout

This block is the digital side of a single-wire, open-drain serial line transceiver of the ISO 9141 kind. The host drives a transmit level. A low level asks the block to turn on the line pull-down, and a high level releases it. An external comparator with hysteresis digitises the line and feeds it back to the block, which passes it to the host as the receive output. The host therefore reads incoming data and also sees its own transmitted bits echoed.

When the pull-down is on but the line still reads high, the line is shorted to the battery rail. A timer counts timebase ticks while this condition lasts. When it reaches a configurable limit, the block releases the pull-down and keeps it released until the host takes the transmit level high and then low again. A fault-disable input from the thermal and overvoltage monitors forces the pull-down off at once. Both asynchronous inputs, transmit and line level, pass through multi-flop synchronisers before any logic uses them.

Top module: `kline_xcvr_ctrl`

## Requirements
- R1: While reset is asserted and just after it is released, `pulldown_en_o` is 0 and `rx_o` is 1 (line idle high).
- R2: With the default two synchroniser stages, the pull-down turns on 3 clock edges after `tx_i` falls and turns off 3 edges after `tx_i` rises, provided no trip and no fault.
- R3: With defaults, `rx_o` equals the `kline_hi_i` value sampled 2 clock edges earlier, whatever the transmit state.
- R4: The timeout counter advances by one on each clock where `tick_i` is 1 while the pull-down is being driven and the synchronised line reads high. On the `SHORT_TICKS`-th such tick the pull-down is released, so it stays on for exactly `SHORT_TICKS` cycles when `tick_i` is held at 1.
- R5: The count clears as soon as the synchronised line reads low, so a later short needs a full `SHORT_TICKS` ticks again.
- R6: The count clears when the synchronised transmit level goes high, so short intervals in separate transmitted low bits do not accumulate.
- R7: After a trip, the pull-down stays off while `tx_i` stays low, whatever the line does.
- R8: A trip is cleared only by a synchronised high-to-low transition of `tx_i`. After that transition the pull-down turns on again with the R2 latency and a fresh count.
- R9: `fault_off_i` = 1 forces `pulldown_en_o` to 0 in the same cycle and holds the count at zero. Releasing it restores the drive at once and restarts the count.
- R10: Clocks with `tick_i` = 0 do not advance the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase strobe, one clock wide |
| tx_i | input | 1 | Transmit level, asynchronous; 0 = pull line low |
| kline_hi_i | input | 1 | Digitised line level, asynchronous; 1 = line high |
| fault_off_i | input | 1 | Thermal or overvoltage disable; 1 = driver forced off |
| pulldown_en_o | output | 1 | Enable of the open-drain pull-down |
| rx_o | output | 1 | Received line level toward the host |

## Verification
A change on `tx_i` reaches `pulldown_en_o` on the third rising edge: two synchroniser flops and then the state register. A change on `kline_hi_i` reaches `rx_o` on the second edge. The trip lands on the `SHORT_TICKS`-th counted tick after the state register enters the drive state. `fault_off_i` acts combinationally, with no edge in its path. The bench drives and samples only on falling edges and counts rising edges from each stimulus to the sample. It compares against a window worked out arithmetically from these latencies: for example, on for edges 3 through `SHORT_TICKS`+2 and off from the next edge. Each check therefore falls either inside a window or on the exact edge where the output must change.

// File: rtl/kline_pkg.sv
`timescale 1ns/1ps
package kline_pkg;

   // Driver state of the transmit path
   typedef enum logic [1:0] {
      KL_IDLE  = 2'd0,   // transmit level high, pull-down released
      KL_DRIVE = 2'd1,   // transmit level low, pull-down on
      KL_TRIP  = 2'd2    // short timeout expired, waiting for a new falling edge
   } kl_state_e;

   // Width able to hold values 0 .. n-1, never less than one bit
   function automatic int unsigned kl_cnt_w(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/kline_sync.sv
`timescale 1ns/1ps
module kline_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("kline_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] stg_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[i] <= RST_VAL;
            else        stg_q[i] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[i] <= RST_VAL;
            else        stg_q[i] <= stg_q[i-1];
         end

         // R3
         sync_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> stg_q[i] == $past(stg_q[i-1]));
      end
   end

   assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/kline_short_timer.sv
`timescale 1ns/1ps
module kline_short_timer #(
   parameter int unsigned SHORT_TICKS = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic arm_i,       // pull-down driven and not disabled
   input  logic line_hi_i,   // synchronised line level
   output logic expire_o
);
   import kline_pkg::*;

   localparam int unsigned CW = kl_cnt_w(SHORT_TICKS);
   localparam logic [CW-1:0] LAST = CW'(SHORT_TICKS - 1);

   if (SHORT_TICKS < 2) begin : g_bad_ticks
      $error("kline_short_timer: SHORT_TICKS must be at least 2");
   end

   logic [CW-1:0] cnt_q;
   logic          short_seen;

   assign short_seen = arm_i & line_hi_i;
   assign expire_o   = short_seen & tick_i & (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!short_seen) begin
         cnt_q <= '0;
      end else if (tick_i) begin
         cnt_q <= expire_o ? '0 : cnt_q + 1'b1;
      end
   end

   // R4
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

   // R5
   line_low_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !line_hi_i |=> cnt_q == '0);

   // R10
   no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (short_seen && !tick_i) |=> $stable(cnt_q));

endmodule

// File: rtl/kline_drv_ctrl.sv
`timescale 1ns/1ps
module kline_drv_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_s_i,      // synchronised transmit level
   input  logic expire_i,    // short timeout reached
   input  logic fault_off_i,
   output logic drive_o,     // state is DRIVE
   output logic pd_en_o
);
   import kline_pkg::*;

   kl_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         KL_IDLE:  if (!tx_s_i) st_d = KL_DRIVE;
         KL_DRIVE: begin
            if (tx_s_i)        st_d = KL_IDLE;
            else if (expire_i) st_d = KL_TRIP;
         end
         KL_TRIP:  if (tx_s_i) st_d = KL_IDLE;
         default:  st_d = KL_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= KL_IDLE;
      else        st_q <= st_d;
   end

   assign drive_o = (st_q == KL_DRIVE);
   assign pd_en_o = drive_o & ~fault_off_i;

   // R7
   trip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == KL_TRIP && !tx_s_i) |=> !pd_en_o);

   // R8
   rearm_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(st_q) == KL_TRIP |-> st_q != KL_DRIVE);

endmodule

// File: rtl/kline_xcvr_ctrl.sv
`timescale 1ns/1ps
module kline_xcvr_ctrl #(
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned SHORT_TICKS  = 20,
   parameter bit          RX_EXTRA_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic tx_i,
   input  logic kline_hi_i,
   input  logic fault_off_i,
   output logic pulldown_en_o,
   output logic rx_o
);

   logic tx_s;
   logic line_s;
   logic expire;
   logic drive;

   kline_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_tx_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (tx_i),
      .q_o   (tx_s)
   );

   kline_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_line_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (kline_hi_i),
      .q_o   (line_s)
   );

   kline_short_timer #(.SHORT_TICKS(SHORT_TICKS)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick_i),
      .arm_i     (drive & ~fault_off_i),
      .line_hi_i (line_s),
      .expire_o  (expire)
   );

   kline_drv_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .tx_s_i      (tx_s),
      .expire_i    (expire),
      .fault_off_i (fault_off_i),
      .drive_o     (drive),
      .pd_en_o     (pulldown_en_o)
   );

   if (RX_EXTRA_REG) begin : g_rx_reg
      logic rx_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rx_q <= 1'b1;
         else        rx_q <= line_s;
      end
      assign rx_o = rx_q;
   end else begin : g_rx_direct
      assign rx_o = line_s;
   end

   // R2
   drive_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulldown_en_o) |-> !fault_off_i && $past(!tx_s || fault_off_i));

   // R9
   fault_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_off_i |=> !expire);

endmodule

// File: tb/tb_kline_xcvr_ctrl.sv
`timescale 1ns/1ps
module tb_kline_xcvr_ctrl;

   localparam int S = 6;

   logic clk = 1'b0;
   logic rst_n, tick, tx, line, fault;
   logic pd, rx;
   logic echo;
   int   n_run = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   always #10 clk = ~clk;

   kline_xcvr_ctrl #(.SYNC_STAGES(2), .SHORT_TICKS(S), .RX_EXTRA_REG(1'b0)) dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .tick_i        (tick),
      .tx_i          (tx),
      .kline_hi_i    (line),
      .fault_off_i   (fault),
      .pulldown_en_o (pd),
      .rx_o          (rx)
   );

   task automatic check(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step();
      @(negedge clk);
      if (echo) line = ~pd;
      #1;
   endtask

   task automatic steps(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   // Transmit low into a line stuck high: on for edges 3 .. S+2, then off
   task automatic profile(input string req);
      tx = 1'b0;
      for (int k = 1; k <= S + 6; k++) begin
         step();
         check(req, pd, (k >= 3 && k <= S + 2) ? 1 : 0);
      end
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic hist [0:63];
      rst_n = 1'b0; tick = 1'b1; tx = 1'b1; line = 1'b1; fault = 1'b0; echo = 1'b0;
      steps(3);
      check("R1 pd in reset", pd, 0);
      check("R1 rx in reset", rx, 1);
      rst_n = 1'b1;
      steps(4);
      check("R1 pd after reset", pd, 0);
      check("R1 rx after reset", rx, 1);

      // R2 / R4: on after three edges, trip after S counted ticks
      profile("R4 short profile");

      // R7: tripped and tx still low, line activity ignored
      for (int i = 0; i < 20; i++) begin
         line = (i % 3) != 0;
         step();
         check("R7 trip holds", pd, 0);
      end
      line = 1'b1;

      // R8: re-arm by high then low, bus echoes the pull-down
      tx = 1'b1; steps(5);
      tx = 1'b0; echo = 1'b1;
      steps(3);
      check("R8 rearm on", pd, 1);
      steps(40);
      check("R5 echoed low no trip", pd, 1);
      check("R3 rx sees own low", rx, 0);
      // R2: release latency
      tx = 1'b1;
      steps(2);
      check("R2 still on at edge 2", pd, 1);
      step();
      check("R2 off at edge 3", pd, 0);
      echo = 1'b0; line = 1'b1; steps(5);

      // R6: partial short in one low bit, then a full count in the next
      tx = 1'b0; steps(S - 2);
      tx = 1'b1; steps(6);
      check("R6 released between bits", pd, 0);
      profile("R6 fresh count");
      tx = 1'b1; steps(5);

      // R5: short interrupted by a low line reading
      tx = 1'b0; line = 1'b1; steps(S);
      line = 1'b0; steps(4);
      line = 1'b1;
      for (int m = 1; m <= S + 2; m++) begin
         step();
         if (m == 3)     check("R5 no early trip", pd, 1);
         if (m == S + 1) check("R5 still on", pd, 1);
         if (m == S + 2) check("R5 trip after full count", pd, 0);
      end
      tx = 1'b1; steps(5);

      // R10: no tick, no count
      tick = 1'b0; tx = 1'b0; steps(40);
      check("R10 no tick keeps drive", pd, 1);
      tick = 1'b1;
      for (int m = 1; m <= S; m++) begin
         step();
         if (m == S - 1) check("R10 on before limit", pd, 1);
         if (m == S)     check("R10 trip at limit", pd, 0);
      end
      tx = 1'b1; steps(5);

      // R9: fault forces off and holds count
      fault = 1'b1; tx = 1'b0;
      for (int i = 0; i < 3 * S; i++) begin
         step();
         if (i % 4 == 3) check("R9 forced off", pd, 0);
      end
      fault = 1'b0; #1;
      check("R9 immediate restore", pd, 1);
      for (int m = 1; m <= S; m++) begin
         step();
         if (m == S - 1) check("R9 count restarted", pd, 1);
         if (m == S)     check("R9 trip after release", pd, 0);
      end
      tx = 1'b1; steps(5);
      tx = 1'b0; steps(3);
      check("R9 drive before fault", pd, 1);
      fault = 1'b1; #1;
      check("R9 same-cycle off", pd, 0);
      fault = 1'b0; tx = 1'b1; steps(5);

      // R3: receive path sweep, value applied two edges earlier
      for (int n = 0; n < 40; n++) begin
         @(negedge clk); #1;
         if (n >= 2) check("R3 rx delay", rx, hist[n-2]);
         hist[n] = (((n * 5) + (n / 3)) % 2) == 1;
         line = hist[n];
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule